// File: doc/BRIEF.md
# I2C Bus Error and Event Flag Monitor

This block runs beside a byte-transfer engine on an I2C node and keeps the bus error and event flags. It takes the raw SCL and SDA line levels and passes them through synchronizers. From the synchronized samples it detects start and stop conditions and counts SCL pulses inside each 9-pulse frame. It then reports three kinds of trouble: a start or stop that arrives in the middle of a byte, a missing acknowledge while transmitting, and lost arbitration while mastering the bus.

It also keeps a bus-busy indicator and a master-mode bit. The master-mode bit drops by itself when arbitration is lost. An event flag collects the three error flags, and a level interrupt request follows that event flag when interrupts are enabled. A start or stop that lands on the first or second pulse of a frame is deliberately not reported as a bus error; it only clears the busy indicator. A status read made while the ninth pulse of a transmitted byte is still high, with the line still not acknowledged, re-raises the acknowledge-failure flag straight away.

The block never drives SCL. The surrounding engine keeps control of both lines, and the host releases SDA after an error.

Top module: `i2c_err_monitor`

## Requirements
- R1: A start condition (SDA falls while SCL is high on two consecutive synchronized samples) sets `busy` when the pulse count is 0 or above 2. A stop condition (SDA rises while SCL is high) always clears `busy`. Both reset the pulse count to 0.
- R2: A start or stop seen while the pulse count is 3 to 9 sets `bus_err` and `evt`.
- R3: A start or stop seen while the pulse count is 1 or 2 leaves `bus_err` unchanged and clears `busy`.
- R4: With `tx_dir`=1, SDA sampled high on the SCL rising edge that begins pulse 9 sets `ack_fail` and `evt`. With `tx_dir`=0 that edge sets nothing.
- R5: A one-cycle `sr2_read` clears `bus_err`, `ack_fail` and `arb_lost`. If the read comes while pulse 9 of a transmitted byte is still high and SDA is still high, `ack_fail` stays set.
- R6: In master mode with `tx_dir`=1, an SCL rising edge of data pulses 1 to 8 on which the node releases SDA (`sda_drv_low`=0) but samples it low sets `arb_lost` and `evt`, and clears `master_mode`.
- R7: `irq` equals `evt` ANDed with `int_en`. `evt` clears once none of the three error flags is set.
- R8: A `start_req` or `stop_req` pulse clears all three error flags. A `start_req` also loads `master_mode` from `mode_in`.
- R9: After reset, `busy`, `master_mode`, all error flags, `evt` and `irq` are 0.
- R10: SDA low on pulse 9 (the acknowledge slot) while the node releases it is a normal acknowledge. It does not set `arb_lost` and leaves `master_mode` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_pin | input | 1 | Raw SCL line level |
| sda_pin | input | 1 | Raw SDA line level |
| sda_drv_low | input | 1 | Local node is pulling SDA low |
| mode_in | input | 1 | Master (1) or slave (0) mode loaded on a start request |
| tx_dir | input | 1 | Node is transmitting the current byte |
| int_en | input | 1 | Interrupt enable |
| sr2_read | input | 1 | Status register read strobe |
| start_req | input | 1 | Start request strobe from the host |
| stop_req | input | 1 | Stop request strobe from the host |
| busy | output | 1 | Bus busy indicator |
| master_mode | output | 1 | Current master-mode bit |
| bus_err | output | 1 | Misplaced start/stop flag |
| ack_fail | output | 1 | Acknowledge failure flag |
| arb_lost | output | 1 | Arbitration lost flag |
| evt | output | 1 | Event flag |
| irq | output | 1 | Interrupt request |

## Verification
A change on a line pin reaches the synchronized sample on the second clock edge. It is compared with the previous sample in the same cycle, and the flags, `busy`, `master_mode` and `irq` register on the third edge. A strobe such as `sr2_read`, `start_req` or `stop_req` takes effect on the first edge. The bench changes inputs only on falling edges and then waits four full cycles before it samples any output. Every line step therefore sits one cycle past its latest due point, and no check depends on process order at an edge.

// File: rtl/i2c_errmon_pkg.sv
package i2c_errmon_pkg;
  typedef struct packed {
    logic bus_err;
    logic ack_fail;
    logic arb_lost;
  } err_flags_t;

  typedef enum logic [1:0] {
    LINE_SCL = 2'd0,
    LINE_SDA = 2'd1
  } line_idx_e;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  import i2c_errmon_pkg::*;

  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_s;
  logic [NLINES-1:0] line_p;

  assign line_raw[LINE_SCL] = scl_pin;
  assign line_raw[LINE_SDA] = sda_pin;

  // one synchronizer chain per line; idle bus level is high
  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[SYNC_STAGES-2:0], line_raw[g]};
    end
    assign line_s[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) line_p <= '1;
    else     line_p <= line_s;
  end

  assign scl_lvl   = line_s[LINE_SCL];
  assign sda_lvl   = line_s[LINE_SDA];
  assign scl_rise  = line_s[LINE_SCL] & ~line_p[LINE_SCL];
  assign scl_fall  = ~line_s[LINE_SCL] & line_p[LINE_SCL];
  assign start_det = line_s[LINE_SCL] & line_p[LINE_SCL] &
                     line_p[LINE_SDA] & ~line_s[LINE_SDA];
  assign stop_det  = line_s[LINE_SCL] & line_p[LINE_SCL] &
                     ~line_p[LINE_SDA] & line_s[LINE_SDA];

  p_cond_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    !(start_det && stop_det));
endmodule

// File: rtl/i2c_pulse_cnt.sv
module i2c_pulse_cnt #(
  parameter int FRAME_PULSES = 9,
  parameter int CNT_W        = $clog2(FRAME_PULSES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             cond_det,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_PULSES);

  always_ff @(posedge clk) begin
    if (rst || cond_det)                cnt <= '0;
    else if (scl_fall && cnt == LAST)   cnt <= '0;
    else if (scl_rise && cnt != LAST)   cnt <= cnt + 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_cnt_cond_clear_r1: assert property (@(posedge clk) disable iff (rst)
    cond_det |=> cnt == '0);
endmodule

// File: rtl/i2c_bus_state.sv
module i2c_bus_state (
  input  logic clk,
  input  logic rst,
  input  logic start_det,
  input  logic stop_det,
  input  logic early_win,
  input  logic arb_evt,
  input  logic start_req,
  input  logic mode_in,
  output logic busy,
  output logic master_mode
);
  always_ff @(posedge clk) begin
    if (rst)                          busy <= 1'b0;
    else if (start_det && !early_win) busy <= 1'b1;
    else if (start_det || stop_det)   busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            master_mode <= 1'b0;
    else if (arb_evt)   master_mode <= 1'b0;
    else if (start_req) master_mode <= mode_in;
  end

  p_early_busy_r3: assert property (@(posedge clk) disable iff (rst)
    ((start_det || stop_det) && early_win) |=> !busy);
  p_stop_busy_r1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);
  p_arb_master_r6: assert property (@(posedge clk) disable iff (rst)
    arb_evt |=> !master_mode);
endmodule

// File: rtl/i2c_err_flags.sv
module i2c_err_flags (
  input  logic clk,
  input  logic rst,
  input  logic berr_evt,
  input  logic nack_evt,
  input  logic ack_reraise,
  input  logic arb_evt,
  input  logic sr2_read,
  input  logic start_req,
  input  logic stop_req,
  input  logic int_en,
  output logic bus_err,
  output logic ack_fail,
  output logic arb_lost,
  output logic evt,
  output logic irq
);
  import i2c_errmon_pkg::*;

  err_flags_t flg_q, flg_n;
  logic       clr;
  logic       set_any;
  logic       evt_n;

  assign clr     = sr2_read | start_req | stop_req;
  assign set_any = berr_evt | nack_evt | ack_reraise | arb_evt;

  always_comb begin
    flg_n = flg_q;
    if (clr) flg_n = '0;
    if (berr_evt)                flg_n.bus_err  = 1'b1;
    if (nack_evt || ack_reraise) flg_n.ack_fail = 1'b1;
    if (arb_evt)                 flg_n.arb_lost = 1'b1;
    evt_n = set_any | (evt & (|flg_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q <= '0;
      evt   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      flg_q <= flg_n;
      evt   <= evt_n;
      irq   <= evt_n & int_en;
    end
  end

  assign bus_err  = flg_q.bus_err;
  assign ack_fail = flg_q.ack_fail;
  assign arb_lost = flg_q.arb_lost;

  p_evt_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_err || ack_fail || arb_lost) |-> !evt);
  p_irq_enable_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(int_en));
  p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (sr2_read && !nack_evt && !ack_reraise) |=> !ack_fail);
  p_req_clears_r8: assert property (@(posedge clk) disable iff (rst)
    ((start_req || stop_req) && !set_any) |=> !(bus_err || ack_fail || arb_lost));
endmodule

// File: rtl/i2c_err_monitor.sv
module i2c_err_monitor #(
  parameter int SYNC_STAGES   = 2,
  parameter int FRAME_PULSES  = 9,
  parameter int EARLY_PULSES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_pin,
  input  logic sda_pin,
  input  logic sda_drv_low,
  input  logic mode_in,
  input  logic tx_dir,
  input  logic int_en,
  input  logic sr2_read,
  input  logic start_req,
  input  logic stop_req,
  output logic busy,
  output logic master_mode,
  output logic bus_err,
  output logic ack_fail,
  output logic arb_lost,
  output logic evt,
  output logic irq
);
  localparam int CNT_W = $clog2(FRAME_PULSES + 1);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(FRAME_PULSES);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(FRAME_PULSES - 1);
  localparam logic [CNT_W-1:0] EARLY_LAST = CNT_W'(EARLY_PULSES);

  logic             scl_lvl, sda_lvl, scl_rise, scl_fall;
  logic             start_det, stop_det, cond_det;
  logic [CNT_W-1:0] cnt;
  logic             early_win, late_win;
  logic             berr_evt, nack_evt, ack_reraise, arb_evt;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst(rst), .scl_pin(scl_pin), .sda_pin(sda_pin),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  assign cond_det = start_det | stop_det;

  i2c_pulse_cnt #(.FRAME_PULSES(FRAME_PULSES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .cond_det(cond_det), .cnt(cnt)
  );

  // frame position decode
  assign early_win = (cnt != '0) && (cnt <= EARLY_LAST);
  assign late_win  = (cnt > EARLY_LAST);

  assign berr_evt    = cond_det & late_win;
  assign nack_evt    = scl_rise & (cnt == DATA_LAST) & tx_dir & sda_lvl;
  assign ack_reraise = sr2_read & (cnt == LAST_PULSE) & scl_lvl & tx_dir & sda_lvl;
  assign arb_evt     = scl_rise & master_mode & tx_dir & ~sda_drv_low &
                       ~sda_lvl & (cnt < DATA_LAST);

  i2c_bus_state u_state (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .early_win(early_win), .arb_evt(arb_evt), .start_req(start_req),
    .mode_in(mode_in), .busy(busy), .master_mode(master_mode)
  );

  i2c_err_flags u_flags (
    .clk(clk), .rst(rst), .berr_evt(berr_evt), .nack_evt(nack_evt),
    .ack_reraise(ack_reraise), .arb_evt(arb_evt), .sr2_read(sr2_read),
    .start_req(start_req), .stop_req(stop_req), .int_en(int_en),
    .bus_err(bus_err), .ack_fail(ack_fail), .arb_lost(arb_lost),
    .evt(evt), .irq(irq)
  );

  p_berr_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_err) |-> $past(cond_det));
  p_early_no_berr_r3: assert property (@(posedge clk) disable iff (rst)
    (cond_det && early_win && !bus_err && !start_req) |=> !bus_err || $past(sr2_read));
  p_rx_no_af_r4: assert property (@(posedge clk) disable iff (rst)
    (!tx_dir && !ack_fail) |=> !ack_fail);
  p_ack_slot_r10: assert property (@(posedge clk) disable iff (rst)
    (scl_rise && cnt == DATA_LAST && !arb_lost) |=> !arb_lost);
endmodule

// File: tb/i2c_err_monitor_test.sv
module i2c_err_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;
  localparam logic [1:0] OP_START = 2'd0, OP_STOP = 2'd1, OP_BIT = 2'd2;

  // {op, sda line, sda_drv_low, expected {busy,bus_err,ack_fail,arb_lost,irq}}
  localparam logic [8:0] VEC [NVEC] = '{
    {OP_START, 1'b0, 1'b0, 5'b10000},
    {OP_BIT,   1'b1, 1'b0, 5'b10000},
    {OP_BIT,   1'b0, 1'b1, 5'b10000},
    {OP_BIT,   1'b1, 1'b0, 5'b10000},
    {OP_BIT,   1'b0, 1'b1, 5'b10000},
    {OP_BIT,   1'b0, 1'b1, 5'b10000},
    {OP_BIT,   1'b1, 1'b0, 5'b10000},
    {OP_BIT,   1'b0, 1'b1, 5'b10000},
    {OP_BIT,   1'b1, 1'b0, 5'b10000},
    {OP_BIT,   1'b0, 1'b0, 5'b10000},
    {OP_STOP,  1'b0, 1'b0, 5'b00000},
    {OP_START, 1'b0, 1'b0, 5'b10000},
    {OP_BIT,   1'b0, 1'b1, 5'b10000},
    {OP_BIT,   1'b0, 1'b1, 5'b10000},
    {OP_BIT,   1'b1, 1'b0, 5'b10000},
    {OP_BIT,   1'b1, 1'b0, 5'b10000},
    {OP_BIT,   1'b1, 1'b0, 5'b10000},
    {OP_BIT,   1'b1, 1'b0, 5'b10000},
    {OP_BIT,   1'b0, 1'b1, 5'b10000},
    {OP_BIT,   1'b0, 1'b1, 5'b10000},
    {OP_BIT,   1'b1, 1'b0, 5'b10101},
    {OP_STOP,  1'b0, 1'b0, 5'b00101}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_pin = 1'b1, sda_pin = 1'b1, sda_drv_low = 1'b0;
  logic mode_in = 1'b1, tx_dir = 1'b1, int_en = 1'b1;
  logic sr2_read = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic busy, master_mode, bus_err, ack_fail, arb_lost, evt, irq;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_err_monitor uut (
    .clk(clk), .rst(rst), .scl_pin(scl_pin), .sda_pin(sda_pin),
    .sda_drv_low(sda_drv_low), .mode_in(mode_in), .tx_dir(tx_dir),
    .int_en(int_en), .sr2_read(sr2_read), .start_req(start_req),
    .stop_req(stop_req), .busy(busy), .master_mode(master_mode),
    .bus_err(bus_err), .ack_fail(ack_fail), .arb_lost(arb_lost),
    .evt(evt), .irq(irq)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic op_start();
    sda_pin = 1'b1; sda_drv_low = 1'b0; settle();
    scl_pin = 1'b1; settle();
    sda_pin = 1'b0; sda_drv_low = 1'b1; settle();
    scl_pin = 1'b0; settle();
  endtask

  task automatic op_stop();
    sda_pin = 1'b0; sda_drv_low = 1'b1; settle();
    scl_pin = 1'b1; settle();
    sda_pin = 1'b1; sda_drv_low = 1'b0; settle();
  endtask

  task automatic op_bit(input logic line, input logic drv);
    scl_pin = 1'b0; settle();
    sda_pin = line; sda_drv_low = drv; settle();
    scl_pin = 1'b1; settle();
    scl_pin = 1'b0; settle();
  endtask

  task automatic pulse_read();
    sr2_read = 1'b1; @(negedge clk); sr2_read = 1'b0; settle();
  endtask

  task automatic pulse_start_req();
    start_req = 1'b1; @(negedge clk); start_req = 1'b0; settle();
  endtask

  task automatic pulse_stop_req();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0; settle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9", "reset outputs", {1'b0, busy, master_mode, bus_err, ack_fail, arb_lost, evt, irq}, 8'h00);

    // R1 R2 R4 R7: vector table of line operations
    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][8:7])
        OP_START: op_start();
        OP_STOP:  op_stop();
        default:  op_bit(VEC[i][6], VEC[i][5]);
      endcase
      check("R1/R4 table", $sformatf("step %0d", i),
            {3'b000, busy, bus_err, ack_fail, arb_lost, irq}, {3'b000, VEC[i][4:0]});
    end

    // R5: status read clears the acknowledge failure
    pulse_read();
    check("R5", "ack_fail after read", {7'd0, ack_fail}, 8'd0);
    check("R7", "evt/irq with no flag", {6'd0, evt, irq}, 8'd0);

    // R3: stop on the first pulse
    op_start();
    check("R1", "busy after start", {7'd0, busy}, 8'd1);
    op_stop();
    check("R3", "early stop busy/bus_err", {6'd0, busy, bus_err}, 8'd0);

    // R3: start on the second pulse
    op_start();
    op_bit(1'b1, 1'b0);
    op_start();
    check("R3", "early start busy/bus_err", {6'd0, busy, bus_err}, 8'd0);
    op_stop();

    // R2: stop on pulse 4 with interrupts masked
    int_en = 1'b0;
    op_start();
    op_bit(1'b1, 1'b0);
    op_bit(1'b0, 1'b1);
    op_bit(1'b1, 1'b0);
    op_stop();
    check("R2", "bus_err/evt after late stop", {6'd0, bus_err, evt}, 8'd3);
    check("R7", "irq masked", {7'd0, irq}, 8'd0);
    check("R1", "busy after stop", {7'd0, busy}, 8'd0);
    int_en = 1'b1; settle();
    check("R7", "irq after enable", {7'd0, irq}, 8'd1);
    pulse_stop_req();
    check("R8", "stop_req clears bus_err/evt/irq", {5'd0, bus_err, evt, irq}, 8'd0);

    // R5: early read during pulse 9 re-raises ack_fail
    op_start();
    for (int k = 0; k < 8; k++) op_bit(1'b1, 1'b0);
    scl_pin = 1'b0; settle();
    sda_pin = 1'b1; sda_drv_low = 1'b0; settle();
    scl_pin = 1'b1; settle();
    check("R4", "nack sets ack_fail", {7'd0, ack_fail}, 8'd1);
    pulse_read();
    check("R5", "early read re-raise", {6'd0, ack_fail, irq}, 8'd3);
    scl_pin = 1'b0; settle();
    pulse_read();
    check("R5", "late read clears", {7'd0, ack_fail}, 8'd0);

    // R8: a start request resumes after a nack
    for (int k = 0; k < 9; k++) op_bit(1'b1, 1'b0);
    check("R4", "second nack", {7'd0, ack_fail}, 8'd1);
    pulse_start_req();
    check("R8", "start_req clears ack_fail/evt", {6'd0, ack_fail, evt}, 8'd0);
    check("R8", "start_req loads master_mode", {7'd0, master_mode}, 8'd1);
    op_stop();

    // R4: receive direction ignores a nack
    tx_dir = 1'b0;
    op_start();
    for (int k = 0; k < 9; k++) op_bit(1'b1, 1'b0);
    check("R4", "receive nack ignored", {6'd0, ack_fail, evt}, 8'd0);
    op_stop();
    tx_dir = 1'b1;

    // R10: acknowledge slot driven low by the slave
    op_start();
    for (int k = 0; k < 8; k++) op_bit(1'b0, 1'b1);
    op_bit(1'b0, 1'b0);
    check("R10", "ack slot arb_lost/master", {6'd0, arb_lost, master_mode}, 8'd1);
    op_stop();

    // R6: arbitration lost on a released data bit
    op_start();
    op_bit(1'b0, 1'b0);
    check("R6", "arb_lost/master/irq", {5'd0, arb_lost, master_mode, irq}, 8'd5);
    op_stop();
    pulse_stop_req();
    check("R8", "stop_req clears arb_lost", {6'd0, arb_lost, evt}, 8'd0);
    check("R6", "master stays cleared", {7'd0, master_mode}, 8'd0);

    done = 1'b1;
    finish_run();
  end
endmodule